// File: doc/BRIEF.md
# Three-Phase Switch Dead-Time Inserter

This block sits between the compare logic of a motor-control timer and the gate drivers of a three-phase inverter. Each phase gets one compare-state bit. The block turns that bit into a complementary pair of switch commands: a highside command that is active while the bit is 1 and a lowside command that is active while the bit is 0. Power switches often turn on faster than they turn off. To keep the two switches of a bridge leg from conducting together, the newly activated command is held off for a programmable dead time after each change of the state bit. The command that is being switched off drops at once.

Every phase has its own one-shot down counter. An enabled change of the phase's state bit reloads that counter from a dead-time value that all phases share. The counter then steps down once per timer count-enable tick and parks at zero. Each phase reports through a flag that its counter has run out. When a phase's enable is cleared, its counter is never started and its outputs follow the state bit with no gap.

Top module: `deadtime_gen3`

## Requirements
- R1: For each phase the highside output is active only while the state bit is 1 and the lowside output only while it is 0; the two are never active together.
- R2: With the phase enabled, any change of its state bit, rising or falling, reloads the phase counter from the dead-time input at the next clock edge; with a non-zero value the expired flag reads 0 from that edge on.
- R3: A running counter decrements by one on each clock edge where the tick input is 1 and holds its value while tick is 0.
- R4: The newly active output asserts when the counter reaches zero: with tick held at 1 and dead-time value D, it is first seen active after D+1 clock edges counted from the edge that samples the state change.
- R5: The output that becomes passive drops in the same cycle the state bit changes, before any clock edge.
- R6: The counter stops at zero without wrapping; the expired flag stays 1 and the active output stays on until the next trigger.
- R7: A state change while counting reloads the full dead-time value; both outputs of that phase stay inactive until the reloaded count reaches zero.
- R8: A dead-time value of 0 inserts no count: the newly active output asserts right after the first clock edge following the state change.
- R9: With a phase's enable at 0 the counter is not started (expired flag stays 1), and the outputs follow the state bit directly: highside equals the bit, lowside its inverse.
- R10: The one dead-time input serves all three phases; phases triggered in the same cycle expire in the same cycle.
- R11: Synchronous reset clears all counters (expired flags read 1 after the reset edge) and holds all six switch outputs inactive while reset is 1.
- R12: When a trigger and a tick fall on the same edge, the reload wins and the tick is not applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable shared with the main timer |
| dt_val | input | 6 | Dead-time reload value shared by all phases |
| ch_en | input | 3 | Per-phase dead-time enable |
| state_in | input | 3 | Per-phase compare-state bit |
| hi_out | output | 3 | Highside switch commands, active high |
| lo_out | output | 3 | Lowside switch commands, active high |
| dt_done | output | 3 | Per-phase flag: dead-time counter at zero |

## Verification
The reload caused by a state change and the decrement caused by the tick can land on the same clock edge. The bench provokes this by letting a phase count down to 1 with tick held at 1 and then flipping its state bit just before the next edge. It then judges the outcome from the expired flag and from the newly active output. The flag must stay 0 after that edge, and the output must appear only after the full reloaded count, not one count early.

// File: rtl/deadtime_pkg.sv
`timescale 1ns/1ps
package deadtime_pkg;
   localparam int unsigned DEF_NUM_CH = 3;
   localparam int unsigned DEF_CNT_W  = 6;

   typedef struct packed {
      logic hi;
      logic lo;
   } sw_pair_t;
endpackage

// File: rtl/dt_edge_detect.sv
`timescale 1ns/1ps
module dt_edge_detect (
   input  logic clk,
   input  logic rst,
   input  logic enable,
   input  logic state_now,
   output logic state_q,
   output logic trig
);
   // Reset copies the live bit so leaving reset causes no spurious trigger.
   always_ff @(posedge clk) begin
      state_q <= state_now;
   end

   always_comb begin
      trig = enable & (state_now ^ state_q) & ~rst;
   end
endmodule

// File: rtl/dt_down_counter.sv
`timescale 1ns/1ps
module dt_down_counter #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             tick,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/dt_output_steer.sv
`timescale 1ns/1ps
module dt_output_steer
   import deadtime_pkg::*;
(
   input  logic     rst,
   input  logic     enable,
   input  logic     state_now,
   input  logic     state_q,
   input  logic     expired,
   output sw_pair_t sw
);
   sw_pair_t raw;

   always_comb begin
      if (enable) begin
         // Turn-off follows the live bit; turn-on waits for a settled bit and an empty counter.
         raw.hi = state_now & state_q & expired;
         raw.lo = ~state_now & ~state_q & expired;
      end else begin
         raw.hi = state_now;
         raw.lo = ~state_now;
      end
      sw.hi = raw.hi & ~rst;
      sw.lo = raw.lo & ~rst;
   end
endmodule

// File: rtl/deadtime_gen3.sv
`timescale 1ns/1ps
module deadtime_gen3
   import deadtime_pkg::*;
#(
   parameter int unsigned NUM_CH = DEF_NUM_CH,
   parameter int unsigned CNT_W  = DEF_CNT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [CNT_W-1:0]  dt_val,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] state_in,
   output logic [NUM_CH-1:0] hi_out,
   output logic [NUM_CH-1:0] lo_out,
   output logic [NUM_CH-1:0] dt_done
);
   localparam int unsigned MAX_DT = (1 << CNT_W) - 1;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("deadtime_gen3: NUM_CH out of range");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
      $error("deadtime_gen3: CNT_W out of range");
   end
   if (MAX_DT < 1) begin : g_bad_max
      $error("deadtime_gen3: counter cannot hold a dead time");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic     st_q;
      logic     trig;
      logic     expired;
      sw_pair_t pair;

      dt_edge_detect i_edge (
         .clk       (clk),
         .rst       (rst),
         .enable    (ch_en[c]),
         .state_now (state_in[c]),
         .state_q   (st_q),
         .trig      (trig)
      );

      dt_down_counter #(.CNT_W(CNT_W)) i_cnt (
         .clk      (clk),
         .rst      (rst),
         .load     (trig),
         .tick     (tick),
         .load_val (dt_val),
         .expired  (expired)
      );

      dt_output_steer i_steer (
         .rst       (rst),
         .enable    (ch_en[c]),
         .state_now (state_in[c]),
         .state_q   (st_q),
         .expired   (expired),
         .sw        (pair)
      );

      assign hi_out[c]  = pair.hi;
      assign lo_out[c]  = pair.lo;
      assign dt_done[c] = expired;
   end
endmodule

// File: rtl/deadtime_gen3_chk.sv
`timescale 1ns/1ps
module deadtime_gen3_chk #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CNT_W  = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic [CNT_W-1:0]  dt_val,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] state_in,
   input logic [NUM_CH-1:0] hi_out,
   input logic [NUM_CH-1:0] lo_out,
   input logic [NUM_CH-1:0] dt_done
);
   // R11: outputs held inactive during reset
   p_reset_quiet_r11: assert property (@(posedge clk)
      rst |-> (hi_out == '0) && (lo_out == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R1: never both switches of one leg on
      p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
         !(hi_out[c] && lo_out[c]));

      // R5: passive side follows the live bit without delay
      p_hi_off_fast_r5: assert property (@(posedge clk) disable iff (rst)
         !state_in[c] |-> !hi_out[c]);
      p_lo_off_fast_r5: assert property (@(posedge clk) disable iff (rst)
         state_in[c] |-> !lo_out[c]);

      // R2: enabled change reloads from the shared value
      p_reload_r2: assert property (@(posedge clk) disable iff (rst)
         (ch_en[c] && (state_in[c] != $past(state_in[c])))
         |=> (dt_done[c] == ($past(dt_val) == '0)));

      // R3: without tick and trigger the expired flag cannot move
      p_hold_r3: assert property (@(posedge clk) disable iff (rst)
         (!tick && !(ch_en[c] && (state_in[c] != $past(state_in[c]))))
         |=> $stable(dt_done[c]));

      // R6: an expired counter stays at zero until retriggered
      p_park_r6: assert property (@(posedge clk) disable iff (rst)
         (dt_done[c] && !(ch_en[c] && (state_in[c] != $past(state_in[c]))))
         |=> dt_done[c]);
   end
endmodule

bind deadtime_gen3 deadtime_gen3_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick),
   .dt_val   (dt_val),
   .ch_en    (ch_en),
   .state_in (state_in),
   .hi_out   (hi_out),
   .lo_out   (lo_out),
   .dt_done  (dt_done)
);

// File: tb/test_deadtime_gen3.sv
`timescale 1ns/1ps
module test_deadtime_gen3;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b1;
   logic [5:0] dt_val = '0;
   logic [2:0] ch_en = 3'b111;
   logic [2:0] state_in = 3'b000;
   logic [2:0] hi_out, lo_out, dt_done;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   deadtime_gen3 i_deadtime_gen3 (
      .clk(clk), .rst(rst), .tick(tick), .dt_val(dt_val), .ch_en(ch_en),
      .state_in(state_in), .hi_out(hi_out), .lo_out(lo_out), .dt_done(dt_done)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; state_in = 3'b000;
      cyc();
      chk("R11", "hi during reset", hi_out, 3'b000);
      chk("R11", "lo during reset", lo_out, 3'b000);
      chk("R11", "done after reset edge", dt_done, 3'b111);
      rst = 1'b0;
      cyc();
      chk("R1", "lo with state 0", lo_out, 3'b111);
      chk("R1", "hi with state 0", hi_out, 3'b000);
   endtask

   task automatic t_rise();
      tick = 1'b1; dt_val = 6'd5;
      state_in[0] = 1'b1; #1;
      chk("R5", "ch0 lo drops at once", lo_out[0], 1'b0);
      chk("R1", "ch0 hi not yet", hi_out[0], 1'b0);
      cyc();
      chk("R2", "ch0 done after trigger", dt_done[0], 1'b0);
      repeat (4) cyc();
      chk("R4", "ch0 hi before D+1 edges", hi_out[0], 1'b0);
      cyc();
      chk("R4", "ch0 hi at D+1 edges", hi_out[0], 1'b1);
      chk("R4", "ch0 done at zero", dt_done[0], 1'b1);
      repeat (3) cyc();
      chk("R6", "ch0 done parked", dt_done[0], 1'b1);
      chk("R6", "ch0 hi stays", hi_out[0], 1'b1);
   endtask

   task automatic t_tick_hold();
      tick = 1'b0; dt_val = 6'd3;
      state_in[1] = 1'b1;
      cyc();
      repeat (8) cyc();
      chk("R3", "ch1 done held without tick", dt_done[1], 1'b0);
      chk("R3", "ch1 hi held off without tick", hi_out[1], 1'b0);
      chk("R3", "ch0 unaffected", dt_done[0], 1'b1);
      tick = 1'b1;
      cyc(); cyc();
      chk("R3", "ch1 hi after two ticks", hi_out[1], 1'b0);
      cyc();
      chk("R3", "ch1 hi after three ticks", hi_out[1], 1'b1);
   endtask

   task automatic t_retrigger();
      tick = 1'b1; dt_val = 6'd4;
      state_in[2] = 1'b1;
      cyc(); cyc(); cyc();
      state_in[2] = 1'b0; #1;
      chk("R7", "ch2 hi off on toggle", hi_out[2], 1'b0);
      chk("R7", "ch2 lo off on toggle", lo_out[2], 1'b0);
      cyc();
      chk("R7", "ch2 done after reload", dt_done[2], 1'b0);
      cyc(); cyc(); cyc();
      chk("R7", "ch2 lo before full reload", lo_out[2], 1'b0);
      chk("R7", "ch2 hi stays off", hi_out[2], 1'b0);
      cyc();
      chk("R7", "ch2 lo after full reload", lo_out[2], 1'b1);
   endtask

   task automatic t_collision();
      tick = 1'b1; dt_val = 6'd3;
      state_in[0] = 1'b0;
      cyc(); cyc(); cyc();
      chk("R12", "ch0 counting at one", dt_done[0], 1'b0);
      state_in[0] = 1'b1;
      cyc();
      chk("R12", "ch0 reload beats tick", dt_done[0], 1'b0);
      chk("R12", "ch0 hi held", hi_out[0], 1'b0);
      cyc(); cyc();
      chk("R12", "ch0 hi before full count", hi_out[0], 1'b0);
      cyc();
      chk("R12", "ch0 hi after full count", hi_out[0], 1'b1);
   endtask

   task automatic t_zero();
      dt_val = 6'd0;
      state_in[1] = 1'b0; #1;
      chk("R5", "ch1 hi drops at once", hi_out[1], 1'b0);
      chk("R8", "ch1 lo not same cycle", lo_out[1], 1'b0);
      cyc();
      chk("R8", "ch1 lo after one edge", lo_out[1], 1'b1);
      chk("R8", "ch1 done with zero value", dt_done[1], 1'b1);
   endtask

   task automatic t_disabled();
      dt_val = 6'd7; ch_en[2] = 1'b0;
      state_in[2] = 1'b1; #1;
      chk("R9", "ch2 hi follows bit", hi_out[2], 1'b1);
      chk("R9", "ch2 lo follows inverse", lo_out[2], 1'b0);
      cyc();
      chk("R9", "ch2 counter not started", dt_done[2], 1'b1);
      state_in[2] = 1'b0; #1;
      chk("R9", "ch2 lo follows inverse", lo_out[2], 1'b1);
      cyc();
      chk("R9", "ch2 still not started", dt_done[2], 1'b1);
      ch_en[2] = 1'b1;
      cyc();
      chk("R9", "ch2 lo after re-enable", lo_out[2], 1'b1);
   endtask

   task automatic t_shared();
      tick = 1'b1; dt_val = 6'd2;
      state_in[0] = 1'b0; state_in[1] = 1'b1;
      cyc();
      chk("R10", "ch0/ch1 both loaded", dt_done, 3'b100);
      cyc();
      chk("R10", "ch1 hi still off", hi_out[1], 1'b0);
      chk("R10", "ch0 lo still off", lo_out[0], 1'b0);
      cyc();
      chk("R10", "ch1 hi on together", hi_out[1], 1'b1);
      chk("R10", "ch0 lo on together", lo_out[0], 1'b1);
   endtask

   task automatic t_reset_mid();
      dt_val = 6'd9;
      state_in[0] = 1'b1;
      cyc(); cyc();
      rst = 1'b1;
      cyc();
      chk("R11", "hi during mid reset", hi_out, 3'b000);
      chk("R11", "lo during mid reset", lo_out, 3'b000);
      chk("R11", "counters cleared", dt_done, 3'b111);
      rst = 1'b0;
      cyc();
      chk("R11", "done after release", dt_done, 3'b111);
   endtask

   initial begin
      #(5.0 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_rise();
      t_tick_hold();
      t_retrigger();
      t_collision();
      t_zero();
      t_disabled();
      t_shared();
      t_reset_mid();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule